// File: doc/BRIEF.md
# Combined Enable/Status Interrupt Controller

This block gathers a small group of interrupt sources behind one 32-bit register. A source occupies one bit in the lower half-word of that register, where it is an enable, and a second bit 16 positions higher, where it is a pending flag. Parameters set where the group of sources starts in the lower half-word and how many sources it has. A single level-sensitive line goes to a parent interrupt controller.

A rising edge on a source input sets that source's status bit, whether or not the source is enabled. Software reads the register to find which sources are pending. It clears a status bit by writing 1 to it. A 0 written to a status bit leaves it alone, so one write can change enables and leave pending flags untouched. The same write can also clear chosen flags while it sets the enables.

The output comes from a two-state machine. In `IRQ_QUIET` the line is low. The transition QUIET→RAISED is taken at the clock edge after some status bit and its enable bit are both set. In `IRQ_RAISED` the line is high. The transition RAISED→QUIET is taken at the clock edge after no enabled status bit remains. The register port is a simple single-cycle port with a read strobe, a write strobe, an address and 32-bit data. The address is a parameter, so several copies can be placed at different offsets, for example 0x018, 0x560 and 0x570.

Top module: `cmbirq_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, every enable bit and every status bit is 0, `irq_o` is 0 and `rdata` is 0.
- R2: A write to `REG_ADDR` loads `wdata[FIRST_BIT+i]` into the enable bit of source i, whatever value it held before. A later read returns that value at bit `FIRST_BIT+i`.
- R3: A 0→1 change on `src_i[i]` sets status bit `16+FIRST_BIT+i`, even when the source's enable bit is 0.
- R4: A source input that stays high sets its status bit only once. After software clears the bit, it stays 0 until the input goes low and then high again.
- R5: A write with `wdata[16+FIRST_BIT+i]`=1 clears status bit i at that clock edge. A write with 0 in that position leaves the status bit unchanged.
- R6: When a rising edge of a source and a write-1 clear of the same status bit arrive in the same cycle, the status bit ends up set.
- R7: Register bits outside the configured source field, in both half-words, always read as 0 and ignore writes.
- R8: `irq_o` is 1 in the cycle after a clock edge at which some source has both its status bit and its enable bit set. It returns to 0 one cycle after no such source remains, whether the last one was cleared or masked.
- R9: A read strobe at `REG_ADDR` returns, in `rdata` during the next cycle, the register contents as they stood just before that clock edge. In every other cycle `rdata` is 0.
- R10: A strobe whose address differs from `REG_ADDR` changes no state, and a read at such an address returns 0.
- R11: A copy with `FIRST_BIT`=4, `NUM_SRC`=2 and `REG_ADDR`=0x570 maps source 0 to enable bit 4 and status bit 20, and source 1 to enable bit 5 and status bit 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Source event inputs; a rising edge is the event |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle after a read strobe |
| irq_o | output | 1 | Level interrupt to the parent controller |

## Verification
The source inputs are driven in several ways:
- single pulses on a source that is masked and on one that is enabled, which separate latching an event from signalling it;
- an input held high across a clear, which shows edge capture as opposed to level capture;
- a rising edge in the same cycle as a write-1 clear, which shows which of the two wins.

Write patterns that carry 0s in the status half-word are set against writes that carry 1s there. This separates "leave pending alone" from "clear". Strobes at a foreign address show that the decode is exact. A second copy with a shifted field, given the same stimulus, shows that bits outside its field stay dead.

// File: rtl/cmbirq_pkg.sv
package cmbirq_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned HALF_W = 16;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/cmbirq_status.sv
// Per-source event capture: rising-edge detect and sticky status bit.
module cmbirq_status #(
    parameter int unsigned NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] status_o
);
    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] st_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic rise;
        assign rise = src_i[g] & ~src_q[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                src_q[g] <= 1'b0;
                st_q[g]  <= 1'b0;
            end else begin
                src_q[g] <= src_i[g];
                // a fresh event beats a simultaneous clear
                st_q[g]  <= rise | (st_q[g] & ~clr_i[g]);
            end
        end
    end

    assign status_o = st_q;
endmodule

// File: rtl/cmbirq_regport.sv
// Address decode, enable storage, clear strobes and read-back image.
module cmbirq_regport
    import cmbirq_pkg::*;
#(
    parameter int unsigned          FIRST_BIT = 0,
    parameter int unsigned          NUM_SRC   = 7,
    parameter int unsigned          ADDR_W    = 12,
    parameter logic [ADDR_W-1:0]    REG_ADDR  = 12'h018
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [REG_W-1:0]   wdata,
    input  logic [NUM_SRC-1:0] status_i,
    output logic [NUM_SRC-1:0] enable_o,
    output logic [NUM_SRC-1:0] clr_o,
    output logic [REG_W-1:0]   rdata_o
);
    localparam int unsigned ST_LSB = HALF_W + FIRST_BIT;

    logic               wr_hit;
    logic               rd_hit;
    logic [NUM_SRC-1:0] en_q;
    logic [REG_W-1:0]   image;
    logic [REG_W-1:0]   rd_q;

    assign wr_hit = wr_en && (addr == REG_ADDR);
    assign rd_hit = rd_en && (addr == REG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_hit) begin
            en_q <= wdata[FIRST_BIT +: NUM_SRC];
        end
    end

    assign clr_o = wr_hit ? wdata[ST_LSB +: NUM_SRC] : '0;

    always_comb begin
        image                      = '0;
        image[FIRST_BIT +: NUM_SRC] = en_q;
        image[ST_LSB +: NUM_SRC]    = status_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_hit ? image : '0;
        end
    end

    assign enable_o = en_q;
    assign rdata_o  = rd_q;
endmodule

// File: rtl/cmbirq_irqfsm.sv
// Two-state machine that drives the level interrupt line.
module cmbirq_irqfsm
    import cmbirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    output logic irq_o
);
    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pend_i)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!pend_i) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end
endmodule

// File: rtl/cmbirq_ctrl.sv
module cmbirq_ctrl
    import cmbirq_pkg::*;
#(
    parameter int unsigned       FIRST_BIT = 0,
    parameter int unsigned       NUM_SRC   = 7,
    parameter int unsigned       ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR  = 12'h018
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] status_w;
    logic [NUM_SRC-1:0] enable_w;
    logic [NUM_SRC-1:0] clr_w;
    logic               pend_w;

    cmbirq_status #(.NUM_SRC(NUM_SRC)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_i),
        .clr_i    (clr_w),
        .status_o (status_w)
    );

    cmbirq_regport #(
        .FIRST_BIT (FIRST_BIT),
        .NUM_SRC   (NUM_SRC),
        .ADDR_W    (ADDR_W),
        .REG_ADDR  (REG_ADDR)
    ) u_regport (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .status_i (status_w),
        .enable_o (enable_w),
        .clr_o    (clr_w),
        .rdata_o  (rdata)
    );

    assign pend_w = |(status_w & enable_w);

    cmbirq_irqfsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend_w),
        .irq_o  (irq_o)
    );
endmodule

// File: rtl/cmbirq_chk.sv
module cmbirq_chk #(
    parameter int unsigned       FIRST_BIT = 0,
    parameter int unsigned       NUM_SRC   = 7,
    parameter int unsigned       ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR  = 12'h018
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic               wr_en,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [31:0]        wdata,
    input logic [NUM_SRC-1:0] status_i,
    input logic [NUM_SRC-1:0] enable_i,
    input logic [31:0]        rdata,
    input logic               irq_o
);
    localparam logic [31:0] LO_MASK  = ((32'h1 << NUM_SRC) - 32'h1) << FIRST_BIT;
    localparam logic [31:0] ALL_MASK = LO_MASK | (LO_MASK << 16);

    logic wr_hit;
    logic rd_hit;
    logic pend;
    assign wr_hit = wr_en && (addr == REG_ADDR);
    assign rd_hit = rd_en && (addr == REG_ADDR);
    assign pend   = |(status_i & enable_i);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && rdata == 32'h0)); // R1

    AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> irq_o); // R8

    AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |=> !irq_o); // R8

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> (rdata == 32'h0)); // R9

    AST_RDATA_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> (rdata[FIRST_BIT +: NUM_SRC] == $past(enable_i) &&
                    rdata[16 + FIRST_BIT +: NUM_SRC] == $past(status_i))); // R9

    AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~ALL_MASK) == 32'h0); // R7

    AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (enable_i == $past(wdata[FIRST_BIT +: NUM_SRC]))); // R2

    AST_FOREIGN_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(enable_i)); // R10

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_chk
        AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(src_i[k]) |=> status_i[k]); // R3

        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit && wdata[16 + FIRST_BIT + k] && !src_i[k]) |=> !status_i[k]); // R5

        AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (status_i[k] && !(wr_hit && wdata[16 + FIRST_BIT + k])) |=> status_i[k]); // R5
    end
endmodule

bind cmbirq_ctrl cmbirq_chk #(
    .FIRST_BIT (FIRST_BIT),
    .NUM_SRC   (NUM_SRC),
    .ADDR_W    (ADDR_W),
    .REG_ADDR  (REG_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (src_i),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .status_i (status_w),
    .enable_i (enable_w),
    .rdata    (rdata),
    .irq_o    (irq_o)
);

// File: tb/sim_cmbirq_ctrl.sv
`timescale 1ns/1ps
module sim_cmbirq_ctrl;
    localparam logic [11:0] A0 = 12'h018;
    localparam logic [11:0] A1 = 12'h570;

    typedef struct packed {
        logic [15:0] en;
        logic [15:0] st;
        logic [15:0] sq;
        logic        irq;
        logic [31:0] rd;
    } mst_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sbus = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic        irq0, irq1;

    int    n_run  = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    mst_t m0 = '0;
    mst_t m1 = '0;

    always #2.5 clk = ~clk;

    cmbirq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_i(sbus[6:0]),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata0), .irq_o(irq0)
    );

    cmbirq_ctrl #(.FIRST_BIT(4), .NUM_SRC(2), .ADDR_W(12), .REG_ADDR(A1)) u1 (
        .clk(clk), .rst_n(rst_n), .src_i(sbus[5:4]),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata1), .irq_o(irq1)
    );

    // behavioural reference: one step per clock edge
    function automatic mst_t step(mst_t s, int first, int num, logic [11:0] adr);
        mst_t n = s;
        bit   pend = 1'b0;
        bit   hitw = wr_en && (addr == adr);
        bit   hitr = rd_en && (addr == adr);
        for (int i = first; i < first + num; i++) pend = pend | (s.st[i] & s.en[i]);
        n.irq = pend;
        n.rd  = hitr ? {s.st, s.en} : 32'h0;
        for (int i = first; i < first + num; i++) begin
            bit rise = sbus[i] && !s.sq[i];
            bit clr  = hitw && wdata[16 + i];
            n.st[i] = rise || (s.st[i] && !clr);
            if (hitw) n.en[i] = wdata[i];
        end
        n.sq = sbus;
        return n;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m0 <= '0;
            m1 <= '0;
        end else begin
            m0 <= step(m0, 0, 7, A0);
            m1 <= step(m1, 4, 2, A1);
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            check(cur_req, "u0 irq",   {31'h0, irq0}, {31'h0, m0.irq});
            check(cur_req, "u0 rdata", rdata0, m0.rd);
            check(cur_req, "u1 irq",   {31'h0, irq1}, {31'h0, m1.irq});
            check(cur_req, "u1 rdata", rdata1, m1.rd);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v0, output logic [31:0] v1);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        #0.5;
        v0 = rdata0; v1 = rdata1;
    endtask

    task automatic pulse(input int b);
        @(negedge clk);
        sbus[b] = 1'b1;
        @(negedge clk);
        sbus[b] = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(200000.0 * 5.0);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired during %s", cur_req);
            summary();
        end
    end

    initial begin
        logic [31:0] v0, v1;
        // R1: reset state
        cur_req = "R1";
        idle(3);
        check("R1", "u0 irq in reset", {31'h0, irq0}, 32'h0);
        check("R1", "u0 rdata in reset", rdata0, 32'h0);
        rst_n = 1'b1;
        rd(A0, v0, v1);
        check("R1", "u0 register after reset", v0, 32'h0);

        // R2 / R7: enable write readback, outside bits dead
        cur_req = "R2";
        wr(A0, 32'h0000_FFFF);
        rd(A0, v0, v1);
        check("R2", "u0 enables all set", v0, 32'h0000_007F);
        wr(A0, 32'h0000_0055);
        rd(A0, v0, v1);
        check("R2", "u0 enables 0x55", v0, 32'h0000_0055);
        cur_req = "R7";
        wr(A0, 32'hFF80_FF80);
        rd(A0, v0, v1);
        check("R7", "u0 outside field ignored", v0, 32'h0000_0000);

        // R11: second configuration
        cur_req = "R11";
        wr(A1, 32'h0000_FFFF);
        rd(A1, v0, v1);
        check("R11", "u1 enables bits 5:4", v1, 32'h0000_0030);
        check("R11", "u0 unaffected by u1 address", v0, 32'h0);

        // R3: masked source latches, no irq
        cur_req = "R3";
        wr(A1, 32'h0);
        pulse(2);
        idle(2);
        check("R3", "u0 irq masked", {31'h0, irq0}, 32'h0);
        rd(A0, v0, v1);
        check("R3", "u0 status bit 18", v0, 32'h0004_0000);

        // R8: enabling raises irq, masking drops it
        cur_req = "R8";
        wr(A0, 32'h0000_0004);
        idle(1);
        check("R8", "u0 irq after enable", {31'h0, irq0}, 32'h1);
        wr(A0, 32'h0000_0000);
        idle(1);
        check("R8", "u0 irq after mask", {31'h0, irq0}, 32'h0);

        // R5: zero write keeps status, one write clears
        cur_req = "R5";
        wr(A0, 32'h0000_0004);
        rd(A0, v0, v1);
        check("R5", "u0 status kept by zero write", v0, 32'h0004_0004);
        wr(A0, 32'h0004_0004);
        idle(1);
        check("R5", "u0 irq after clear", {31'h0, irq0}, 32'h0);
        rd(A0, v0, v1);
        check("R5", "u0 status cleared", v0, 32'h0000_0004);

        // R4: held level latches once
        cur_req = "R4";
        @(negedge clk); sbus[3] = 1'b1;
        idle(2);
        wr(A0, 32'h0008_0000);
        idle(3);
        rd(A0, v0, v1);
        check("R4", "u0 held source not relatched", v0, 32'h0000_0000);
        @(negedge clk); sbus[3] = 1'b0;
        pulse(3);
        rd(A0, v0, v1);
        check("R4", "u0 relatch after new edge", v0, 32'h0008_0000);

        // R6: edge and clear in the same cycle
        cur_req = "R6";
        wr(A0, 32'h0008_0000);
        @(negedge clk);
        sbus[1] = 1'b1; wr_en = 1'b1; addr = A0; wdata = 32'h0002_0002;
        @(negedge clk);
        sbus[1] = 1'b0; wr_en = 1'b0; wdata = '0;
        rd(A0, v0, v1);
        check("R6", "u0 event wins over clear", v0, 32'h0002_0002);
        idle(1);
        check("R6", "u0 irq from surviving event", {31'h0, irq0}, 32'h1);

        // R10: foreign address
        cur_req = "R10";
        wr(12'h01C, 32'hFFFF_FFFF);
        rd(12'h01C, v0, v1);
        check("R10", "u0 foreign read", v0, 32'h0);
        rd(A0, v0, v1);
        check("R10", "u0 unchanged by foreign write", v0, 32'h0002_0002);

        // R11 / R7: u1 sees only its own sources
        cur_req = "R11";
        wr(A1, 32'h0000_0010);
        pulse(0);
        pulse(4);
        pulse(5);
        rd(A1, v0, v1);
        check("R11", "u1 status bits 21:20", v1, 32'h0030_0010);
        idle(1);
        check("R11", "u1 irq from source 0", {31'h0, irq1}, 32'h1);
        wr(A1, 32'h0030_0000);
        idle(2);
        check("R11", "u1 irq after clear", {31'h0, irq1}, 32'h0);

        // R9: back-to-back reads, mixed traffic
        cur_req = "R9";
        @(negedge clk); rd_en = 1'b1; addr = A0;
        idle(3);
        rd_en = 1'b0;
        idle(2);
        check("R9", "u0 rdata zero without read", rdata0, 32'h0);

        done = 1'b1;
        summary();
    end
endmodule